// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash. The flash has an active-low chip enable, output enable and write enable. A requester asks for one of three operations: byte program, sector erase or whole-chip erase. The sequencer then produces the unlock write cycles that the flash expects. After the last write it polls the flash with repeated reads at the target address until the flash reports that its internal operation has finished. Completion is reported as a one-cycle done pulse. If the flash never reports completion within a bounded number of status reads, the same done pulse carries a timeout indication, and a sticky error flag is set.

Two completion checks are available, chosen per request. The status-bit check compares bit 7 of each read with the expected final value. The toggle check waits until bit 6 stops changing between two reads in a row. All strobe widths are counted in clock cycles from parameters, so the same RTL serves any clock rate. The read access time, the minimum write-enable low and high times and the data setup time each have their own parameter.

The controller has eight states. IDLE accepts a request (transition *accept*). Each write cycle walks WSETUP (address up, chip enable low) → WLOW (write enable low, data driven) → WHOLD (write enable high, data still driven) → WGAP (bus released). From WGAP, *next step* returns to WSETUP, and *last step* enters RACC. A status read walks RACC (chip and output enable low) → REVAL (judge the byte). From REVAL, *complete* and *expire* return to IDLE, and *retry* passes through RGAP back to RACC.

Top module: `flash_pe_seq`

## Requirements
- R1: A byte program (req_op = 2'b00) issues exactly four write cycles, as address/data pairs in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then target address/request data.
- R2: A sector erase (req_op = 2'b01) or chip erase (req_op = 2'b10) issues exactly six write cycles. The first five are 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h. The sixth is target/30h for a sector erase and 5555h/10h for a chip erase.
- R3: With poll_sel = 0, every status read uses the target address. The operation completes at the first read whose bit 7 equals the expected value: bit 7 of the request data for a program, and 1 for either erase. op_rbyte then holds the final byte read.
- R4: With poll_sel = 1, the operation completes at the first read whose bit 6 equals bit 6 of the read just before it in the same operation. The first read of an operation can never complete it.
- R5: Status reads are counted per operation. The limit is PROG_TMO_POLLS for a program and ERASE_TMO_POLLS for an erase. If read number limit does not complete the operation, the operation ends with op_tmo. A completing match on that same read ends the operation without a timeout.
- R6: While write enable is low, output enable is high, chip enable is low and data is driven. Each write-enable low pulse lasts at least max(WE_LOW_CYC, DSETUP_CYC) cycles. Write enable stays high for at least WE_HIGH_CYC cycles between pulses.
- R7: fl_doe is high only while write enable is low or in the single cycle right after its rising edge.
- R8: A request is taken only while req_ready is high, and req_ready is high only in IDLE. Requests made while an operation runs, and requests with req_op = 2'b11, cause no bus cycle and no done.
- R9: op_done is a one-cycle pulse at the end of every operation. op_tmo pulses together with it on a timeout. op_err is set by a timeout and cleared when the next request is accepted.
- R10: After reset, all three flash strobes are high, fl_doe is low, req_ready is high, and op_done, op_tmo and op_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 rejected |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| poll_sel | input | 1 | 0 bit-7 status check, 1 bit-6 toggle check |
| req_ready | output | 1 | High when idle and able to take a request |
| op_done | output | 1 | One-cycle completion pulse |
| op_tmo | output | 1 | Timeout pulse, coincides with op_done |
| op_err | output | 1 | Sticky error from the last operation |
| op_rbyte | output | 8 | Last status byte read |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dout | output | 8 | Data driven to the flash |
| fl_doe | output | 1 | Data bus drive enable |
| fl_din | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The status read that reaches the poll limit can also be the read that first shows completion. In the REVAL state, completion and timeout therefore meet in the same cycle. The bench's flash model stays busy for a programmable number of status reads. This lets a program and a sector erase each be set so that exactly the limit-th read returns the finished value. The expected result is done without op_tmo or op_err. The same cases are then repeated with the flash busy for one read more, and the expected result is a timeout after exactly limit reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_NONE   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WLOW,
        ST_WHOLD,
        ST_WGAP,
        ST_RACC,
        ST_REVAL,
        ST_RGAP
    } st_e;

    localparam logic [15:0] UNLK_A1 = 16'h5555;
    localparam logic [15:0] UNLK_A2 = 16'h2AAA;
    localparam logic [7:0]  KEY_1   = 8'hAA;
    localparam logic [7:0]  KEY_2   = 8'h55;
    localparam logic [7:0]  CMD_PRG = 8'hA0;
    localparam logic [7:0]  CMD_ERS = 8'h80;
    localparam logic [7:0]  CMD_SEC = 8'h30;
    localparam logic [7:0]  CMD_CHP = 8'h10;

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  op_e               op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] step_addr,
    output logic [7:0]        step_data,
    output logic [2:0]        last_idx
);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLK_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLK_A2);

    always_comb begin
        step_addr = A1;
        step_data = KEY_1;
        last_idx  = (op == OP_PROG) ? 3'd3 : 3'd5;
        unique case (idx)
            3'd0: begin step_addr = A1; step_data = KEY_1; end
            3'd1: begin step_addr = A2; step_data = KEY_2; end
            3'd2: begin
                step_addr = A1;
                step_data = (op == OP_PROG) ? CMD_PRG : CMD_ERS;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    step_addr = tgt;
                    step_data = wdata;
                end else begin
                    step_addr = A1;
                    step_data = KEY_1;
                end
            end
            3'd4: begin step_addr = A2; step_data = KEY_2; end
            3'd5: begin
                if (op == OP_CERASE) begin
                    step_addr = A1;
                    step_data = CMD_CHP;
                end else begin
                    step_addr = tgt;
                    step_data = CMD_SEC;
                end
            end
            default: begin step_addr = A1; step_data = KEY_1; end
        endcase
    end
endmodule

// File: rtl/flash_cyc_timer.sv
module flash_cyc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_poll_unit.sv
module flash_poll_unit #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          eval,
    input  logic          toggle_mode,
    input  logic          exp7,
    input  logic [7:6]    sbits,
    input  logic [CW-1:0] limit,
    output logic          match,
    output logic          at_limit
);
    logic [CW-1:0] n_q;
    logic          prev6_q;
    logic          prev_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q       <= '0;
            prev6_q   <= 1'b0;
            prev_ok_q <= 1'b0;
        end else if (clear) begin
            n_q       <= '0;
            prev6_q   <= 1'b0;
            prev_ok_q <= 1'b0;
        end else if (eval) begin
            n_q       <= n_q + 1'b1;
            prev6_q   <= sbits[6];
            prev_ok_q <= 1'b1;
        end
    end

    assign match    = toggle_mode ? (prev_ok_q && (sbits[6] == prev6_q))
                                  : (sbits[7] == exp7);
    assign at_limit = ((n_q + 1'b1) >= limit);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W          = 19,
    parameter int WE_LOW_CYC      = 2,
    parameter int DSETUP_CYC      = 2,
    parameter int WE_HIGH_CYC     = 1,
    parameter int RD_CYC          = 4,
    parameter int PROG_TMO_POLLS  = 400,
    parameter int ERASE_TMO_POLLS = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              poll_sel,
    output logic              req_ready,
    output logic              op_done,
    output logic              op_tmo,
    output logic              op_err,
    output logic [7:0]        op_rbyte,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dout,
    output logic              fl_doe,
    input  logic [7:0]        fl_din,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    localparam int PULSE_CYC = (WE_LOW_CYC > DSETUP_CYC) ? WE_LOW_CYC : DSETUP_CYC;
    localparam int GAP_CYC   = (WE_HIGH_CYC > 0) ? WE_HIGH_CYC : 1;
    localparam int TMAX_A    = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int TMAX      = (TMAX_A > RD_CYC) ? TMAX_A : RD_CYC;
    localparam int TW        = $clog2(TMAX + 1);
    localparam int PMAX      = (PROG_TMO_POLLS > ERASE_TMO_POLLS) ? PROG_TMO_POLLS : ERASE_TMO_POLLS;
    localparam int CW        = $clog2(PMAX + 1) + 1;

    st_e               state_q, state_d;
    logic [2:0]        step_q, step_d;
    op_e               op_q;
    logic              mode_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [7:0]        wd_q;
    logic [7:0]        rd_q;

    logic              accept, fin_ok, fin_tmo;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              poll_clr, poll_eval, poll_match, poll_limit;
    logic [CW-1:0]     lim;

    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        cur_data;
    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic [2:0]        last_idx;

    assign cur_op   = accept ? op_e'(req_op) : op_q;
    assign cur_addr = accept ? req_addr : tgt_q;
    assign cur_data = accept ? req_data : wd_q;

    flash_cmd_rom #(.ADDR_W(ADDR_W)) u_rom (
        .op        (cur_op),
        .idx       (step_d),
        .tgt       (cur_addr),
        .wdata     (cur_data),
        .step_addr (rom_addr),
        .step_data (rom_data),
        .last_idx  (last_idx)
    );

    flash_cyc_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign lim = (op_q == OP_PROG) ? CW'(PROG_TMO_POLLS) : CW'(ERASE_TMO_POLLS);

    flash_poll_unit #(.CW(CW)) u_poll (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (poll_clr),
        .eval        (poll_eval),
        .toggle_mode (mode_q),
        .exp7        ((op_q == OP_PROG) ? wd_q[7] : 1'b1),
        .sbits       (rd_q[7:6]),
        .limit       (lim),
        .match       (poll_match),
        .at_limit    (poll_limit)
    );

    // next state and step
    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        accept    = 1'b0;
        fin_ok    = 1'b0;
        fin_tmo   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        poll_clr  = 1'b0;
        poll_eval = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (op_e'(req_op) != OP_NONE)) begin
                    accept  = 1'b1;
                    step_d  = 3'd0;
                    state_d = ST_WSETUP;
                end
            end
            ST_WSETUP: begin
                state_d  = ST_WLOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC - 1);
            end
            ST_WLOW: begin
                if (tmr_zero) state_d = ST_WHOLD;
            end
            ST_WHOLD: begin
                state_d  = ST_WGAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(GAP_CYC - 1);
            end
            ST_WGAP: begin
                if (tmr_zero) begin
                    if (step_q == last_idx) begin
                        state_d  = ST_RACC;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RD_CYC - 1);
                        poll_clr = 1'b1;
                    end else begin
                        step_d  = step_q + 3'd1;
                        state_d = ST_WSETUP;
                    end
                end
            end
            ST_RACC: begin
                if (tmr_zero) state_d = ST_REVAL;
            end
            ST_REVAL: begin
                poll_eval = 1'b1;
                if (poll_match) begin
                    fin_ok  = 1'b1;
                    state_d = ST_IDLE;
                end else if (poll_limit) begin
                    fin_tmo = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_RGAP;
                end
            end
            ST_RGAP: begin
                state_d  = ST_RACC;
                tmr_load = 1'b1;
                tmr_val  = TW'(RD_CYC - 1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            op_q    <= OP_PROG;
            mode_q  <= 1'b0;
            tgt_q   <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (accept) begin
                op_q   <= op_e'(req_op);
                mode_q <= poll_sel;
                tgt_q  <= req_addr;
                wd_q   <= req_data;
            end
            if (state_q == ST_RACC && tmr_zero) rd_q <= fl_din;
        end
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_ce_n <= 1'b1;
            fl_oe_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_doe  <= 1'b0;
            fl_addr <= '0;
            fl_dout <= '0;
            op_done <= 1'b0;
            op_tmo  <= 1'b0;
            op_err  <= 1'b0;
        end else begin
            op_done <= fin_ok | fin_tmo;
            op_tmo  <= fin_tmo;
            if (accept)       op_err <= 1'b0;
            else if (fin_tmo) op_err <= 1'b1;
            unique case (state_d)
                ST_WSETUP, ST_WLOW, ST_WHOLD: begin
                    fl_ce_n <= 1'b0;
                    fl_oe_n <= 1'b1;
                    fl_we_n <= (state_d != ST_WLOW);
                    fl_doe  <= (state_d != ST_WSETUP);
                    fl_addr <= rom_addr;
                    fl_dout <= rom_data;
                end
                ST_RACC: begin
                    fl_ce_n <= 1'b0;
                    fl_oe_n <= 1'b0;
                    fl_we_n <= 1'b1;
                    fl_doe  <= 1'b0;
                    fl_addr <= tgt_q;
                end
                default: begin
                    fl_ce_n <= 1'b1;
                    fl_oe_n <= 1'b1;
                    fl_we_n <= 1'b1;
                    fl_doe  <= 1'b0;
                end
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign op_rbyte  = rd_q;

endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
    parameter int WE_LOW_CYC  = 2,
    parameter int DSETUP_CYC  = 2,
    parameter int WE_HIGH_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic fl_we_n,
    input logic fl_oe_n,
    input logic fl_ce_n,
    input logic fl_doe,
    input logic op_done,
    input logic op_tmo,
    input logic op_err,
    input logic req_ready
);
    localparam int PMIN = (WE_LOW_CYC > DSETUP_CYC) ? WE_LOW_CYC : DSETUP_CYC;

    logic [7:0] low_n, high_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_n  <= 8'd0;
            high_n <= 8'hFF;
        end else if (!fl_we_n) begin
            low_n  <= (low_n == 8'hFF) ? low_n : low_n + 8'd1;
            high_n <= 8'd0;
        end else begin
            low_n  <= 8'd0;
            high_n <= (high_n == 8'hFF) ? high_n : high_n + 8'd1;
        end
    end

    a_r6_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_doe));
    a_r6_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (int'(low_n) >= PMIN));
    a_r6_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> (int'(high_n) >= WE_HIGH_CYC));
    a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        fl_doe |-> (!fl_we_n || $past(!fl_we_n)));
    a_r8_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_doe));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    a_r9_tmo_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_tmo |-> (op_done && op_err));

endmodule

bind flash_pe_seq flash_pe_seq_chk #(
    .WE_LOW_CYC  (WE_LOW_CYC),
    .DSETUP_CYC  (DSETUP_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_ce_n   (fl_ce_n),
    .fl_doe    (fl_doe),
    .op_done   (op_done),
    .op_tmo    (op_tmo),
    .op_err    (op_err),
    .req_ready (req_ready)
);

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb;
    localparam int AW = 19;
    localparam int PLIM = 8;
    localparam int ELIM = 12;

    typedef struct packed {
        logic [1:0]    op;
        logic          mode;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    k;
        logic          err;
        logic [7:0]    reads;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 1'b0, 19'h12345, 8'h5A, 8'd3,  1'b0, 8'd4},
        '{2'd0, 1'b1, 19'h00010, 8'h40, 8'd3,  1'b0, 8'd5},
        '{2'd0, 1'b1, 19'h00020, 8'h00, 8'd3,  1'b0, 8'd4},
        '{2'd1, 1'b0, 19'h7C400, 8'h00, 8'd5,  1'b0, 8'd6},
        '{2'd2, 1'b1, 19'h00000, 8'h00, 8'd2,  1'b0, 8'd3},
        '{2'd0, 1'b0, 19'h00100, 8'h33, 8'd7,  1'b0, 8'd8},
        '{2'd0, 1'b0, 19'h00101, 8'h33, 8'd8,  1'b1, 8'd8},
        '{2'd1, 1'b0, 19'h00400, 8'h00, 8'd11, 1'b0, 8'd12},
        '{2'd1, 1'b0, 19'h00800, 8'h00, 8'd12, 1'b1, 8'd12},
        '{2'd0, 1'b1, 19'h00030, 8'h00, 8'd0,  1'b0, 8'd2},
        '{2'd0, 1'b0, 19'h00040, 8'h80, 8'd2,  1'b0, 8'd3},
        '{2'd2, 1'b1, 19'h00000, 8'h00, 8'd20, 1'b1, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'd0;
    logic          poll_sel = 1'b0;
    logic          req_ready, op_done, op_tmo, op_err;
    logic [7:0]    op_rbyte;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dout, fl_din;
    logic          fl_doe, fl_ce_n, fl_oe_n, fl_we_n;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    flash_pe_seq #(
        .ADDR_W(AW), .WE_LOW_CYC(2), .DSETUP_CYC(2), .WE_HIGH_CYC(1),
        .RD_CYC(4), .PROG_TMO_POLLS(PLIM), .ERASE_TMO_POLLS(ELIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .poll_sel(poll_sel),
        .req_ready(req_ready), .op_done(op_done), .op_tmo(op_tmo),
        .op_err(op_err), .op_rbyte(op_rbyte), .fl_addr(fl_addr),
        .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    // behavioural flash model
    logic          m_clr = 1'b0;
    logic [7:0]    m_k = 8'd0;
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];
    int            wcnt, rcnt;
    logic [7:0]    busy_left, ready_val;
    logic          busy7, tog, we_q, oe_q;
    logic [AW-1:0] last_raddr;

    always @(posedge clk) begin
        if (m_clr) begin
            wcnt <= 0; rcnt <= 0; busy_left <= 8'd0; ready_val <= 8'hFF;
            busy7 <= 1'b0; tog <= 1'b0; we_q <= 1'b1; oe_q <= 1'b1;
            last_raddr <= '0;
        end else begin
            we_q <= fl_we_n;
            oe_q <= fl_oe_n;
            if (!we_q && fl_we_n && wcnt < 8) begin
                wa[wcnt] <= fl_addr;
                wd[wcnt] <= fl_dout;
                wcnt <= wcnt + 1;
                if (wcnt == 3 && wd[2] == 8'hA0) begin
                    busy_left <= m_k; ready_val <= fl_dout; busy7 <= ~fl_dout[7];
                end
                if (wcnt == 5) begin
                    busy_left <= m_k; ready_val <= 8'hFF; busy7 <= 1'b0;
                end
            end
            if (!fl_oe_n) last_raddr <= fl_addr;
            if (!oe_q && fl_oe_n) begin
                rcnt <= rcnt + 1;
                if (busy_left != 8'd0) begin
                    busy_left <= busy_left - 8'd1;
                    tog <= ~tog;
                end
            end
        end
    end

    assign fl_din = (busy_left != 8'd0) ? {busy7, tog, 6'b0} : ready_val;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW+7:0] exp_wr(input logic [1:0] op, input int i,
                                             input logic [AW-1:0] a, input logic [7:0] d);
        logic [AW-1:0] u1, u2;
        u1 = AW'(16'h5555);
        u2 = AW'(16'h2AAA);
        case (i)
            0: return {u1, 8'hAA};
            1: return {u2, 8'h55};
            2: return {u1, (op == 2'd0) ? 8'hA0 : 8'h80};
            3: return (op == 2'd0) ? {a, d} : {u1, 8'hAA};
            4: return {u2, 8'h55};
            default: return (op == 2'd2) ? {u1, 8'h10} : {a, 8'h30};
        endcase
    endfunction

    task automatic model_reset(input logic [7:0] k);
        @(negedge clk);
        m_k = k;
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic mode,
                         input logic [AW-1:0] a, input logic [7:0] d);
        req_op = op; poll_sel = mode; req_addr = a; req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic seen, output logic tmo_seen);
        seen = 1'b0;
        tmo_seen = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (op_done) begin
                seen = 1'b1;
                tmo_seen = op_tmo;
                break;
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int n);
        logic seen, tseen;
        int nw;
        model_reset(v.k);
        chk($sformatf("R8 ready before vec %0d", n), req_ready, 1'b1);
        issue(v.op, v.mode, v.addr, v.data);
        chk($sformatf("R9 err cleared on accept vec %0d", n), op_err, 1'b0);
        chk($sformatf("R8 busy after accept vec %0d", n), req_ready, 1'b0);
        wait_done(seen, tseen);
        chk($sformatf("R9 done seen vec %0d", n), seen, 1'b1);
        chk($sformatf("R5 timeout vec %0d", n), tseen, v.err);
        chk($sformatf("R9 err level vec %0d", n), op_err, v.err);
        chk($sformatf("R5 read count vec %0d", n), rcnt, v.reads);
        chk($sformatf("R3 read address vec %0d", n), last_raddr, v.addr);
        nw = (v.op == 2'd0) ? 4 : 6;
        chk($sformatf("%s write count vec %0d", (v.op == 2'd0) ? "R1" : "R2", n), wcnt, nw);
        for (int i = 0; i < nw; i++)
            chk($sformatf("%s write %0d vec %0d", (v.op == 2'd0) ? "R1" : "R2", i, n),
                {wa[i], wd[i]}, exp_wr(v.op, i, v.addr, v.data));
        if (!v.err)
            chk($sformatf("%s final byte vec %0d", v.mode ? "R4" : "R3", n), op_rbyte,
                (v.op == 2'd0) ? v.data : 8'hFF);
        @(negedge clk);
        chk($sformatf("R9 done one cycle vec %0d", n), op_done, 1'b0);
        chk($sformatf("R8 ready after vec %0d", n), req_ready, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic seen, tseen, extra;
        repeat (3) @(negedge clk);
        chk("R10 ce_n", fl_ce_n, 1'b1);
        chk("R10 we_n", fl_we_n, 1'b1);
        chk("R10 oe_n", fl_oe_n, 1'b1);
        chk("R10 doe", fl_doe, 1'b0);
        chk("R10 ready", req_ready, 1'b1);
        chk("R10 flags", {op_done, op_tmo, op_err}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < 12; n++) run_vec(VECS[n], n);

        // op 11 rejected (R8)
        model_reset(8'd0);
        req_op = 2'd3; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 op11 ready held", req_ready, 1'b1);
        req_valid = 1'b0;
        extra = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (op_done) extra = 1'b1;
        end
        chk("R8 op11 no writes", wcnt, 0);
        chk("R8 op11 no done", extra, 1'b0);
        chk("R9 err kept until accept", op_err, 1'b1);

        // request during an operation is ignored (R8)
        model_reset(8'd4);
        issue(2'd1, 1'b0, 19'h00C00, 8'h00);
        chk("R9 err cleared by accept", op_err, 1'b0);
        repeat (5) @(negedge clk);
        req_op = 2'd0; req_addr = 19'h00001; req_data = 8'h11; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen, tseen);
        chk("R8 busy op finished", {seen, tseen}, 2'b10);
        extra = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (op_done) extra = 1'b1;
        end
        chk("R8 busy req no writes", wcnt, 6);
        chk("R8 busy req last cmd", {wa[5], wd[5]}, {19'h00C00, 8'h30});
        chk("R8 busy req no done", extra, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule